// File: doc/BRIEF.md
# Soft-Ramp Digital Volume Stage

This block scales multichannel 24-bit two's-complement audio once per frame. Each channel has an 8-bit attenuation code on a log scale of 0.5 dB per code, with the all-ones code meaning unity gain and the all-zeros code meaning silence. When a code changes, the level the channel actually uses walks toward the new code one code at a time. A two-bit speed select picks the pace of that walk. Separately, a global soft-mute input fades every channel to silence and back along a linear gain ramp. Its gain multiplies with the volume gain.

A frame strobe marks each new set of input samples. On that strobe the block registers the scaled samples, and it raises a one-cycle valid pulse in the following cycle. A run input models the timing-reset control. While run is low, the block bypasses the attenuation and every channel's level snaps to its code. When run returns high, the programmed level takes effect at once.

Top module: `vol_ramp`

## Requirements
- R1: After reset `dout` is all zeros and `dvalid` is 0. Every channel's level starts at code FFh and the mute gain starts at unity, so the first frame with code FFh and soft mute off passes samples through unchanged.
- R2: For a used code c (01h..FFh), the block forms a = 255 − c, s = a div 12 and r = a mod 12. It then computes y = round(x · K[r] · m / 2^(25+s)), rounding half toward +∞. K = {32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396} is indexed by r from 0, and m is the mute gain from 0 to 1024. The result is saturated to 24 bits.
- R3: A used code of 00h gives an output of exactly zero, whatever the sample.
- R4: On each frame where run is high and a channel's level differs from its code, the block adds 255 to that channel's phase. When the phase reaches the span, the level moves one code toward the code and the span is subtracted from the phase. When the level equals the code, the phase clears. The span is 7424 for speed 00 and 1061 for speed 01. A level change therefore affects the output from the next frame.
- R5: For speed 10 or 11 the span is 255, so the level moves one code per frame. With any speed, a full walk from FFh to 00h completes in exactly the span's number of frames: 7424, 1061 or 255.
- R6: On a frame with run low, the output uses code FFh, each level is set to its code and each phase clears. On the first frame with run high again, the programmed code applies with no walk.
- R7: While soft mute is 1, the mute gain drops by one per frame down to 0. While it is 0, the gain rises by one per frame up to 1024. From unity, the first all-zero output appears on frame 1025 after soft mute is set.
- R8: Clearing soft mute partway through a fade reverses the ramp from the gain reached. The gain climbs back to unity by the same number of frames it fell.
- R9: Volume and mute gains multiply, as in the formula of R2, and each follows its own ramp.
- R10: `dvalid` is high exactly in the cycle after a frame strobe. `dout` changes only in that cycle and holds between frames.
- R11: Channels are independent. A channel's code and sample affect only that channel's slice of `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores all levels to FFh |
| run | input | 1 | Timing-reset control; low bypasses attenuation and snaps levels |
| frame | input | 1 | One-cycle strobe per audio frame |
| speed | input | 2 | Walk pace select: 00 slow, 01 medium, 10/11 fast |
| soft_mute | input | 1 | Global fade to silence while high |
| target | input | CH*8 | Attenuation codes, channel c in bits [8c+7:8c] |
| din | input | CH*DW | Input samples, channel c in bits [DW·c+DW−1:DW·c] |
| dout | output | CH*DW | Scaled samples, same packing as din |
| dvalid | output | 1 | High for one cycle after each frame strobe |

## Verification
The hardest state to reach is a level walk that is interrupted. This happens when the speed changes while a phase still holds a remainder, or when a code changes direction mid-walk, and the interaction is most tangled when soft mute is also partway through a fade. Several thousand constrained-random frames produce this state. They change codes at random times, switch speed mid-walk, toggle soft mute and drop run for a single frame, and a frame-accurate bench model predicts every output. Directed walks from FFh to 00h at each speed, together with a partial fade followed by a cancel, pin down the exact frame counts.

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int CH          = 2,
  parameter int DW          = 24,
  parameter int MUTE_FRAMES = 1024,
  parameter int SPAN_SLOW   = 7424,
  parameter int SPAN_MID    = 1061,
  parameter int SPAN_FAST   = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             frame,
  input  logic [1:0]       speed,
  input  logic             soft_mute,
  input  logic [CH*8-1:0]  target,
  input  logic [CH*DW-1:0] din,
  output logic [CH*DW-1:0] dout,
  output logic             dvalid
);
  localparam int STEP = 255;
  localparam int MSH  = $clog2(MUTE_FRAMES);
  localparam int MW   = MSH + 1;
  localparam int AW   = $clog2(SPAN_SLOW + STEP + 1);
  localparam logic signed [63:0] MAXV = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam logic signed [63:0] MINV = -(64'sd1 <<< (DW - 1));

  logic [MW-1:0]     mgain;
  logic [CH*8-1:0]   lvl_all;
  logic [AW:0]       span;

  function automatic logic [15:0] coef_of(input logic [3:0] r);
    case (r)
      4'd0:    coef_of = 16'd32768;
      4'd1:    coef_of = 16'd30935;
      4'd2:    coef_of = 16'd29205;
      4'd3:    coef_of = 16'd27571;
      4'd4:    coef_of = 16'd26029;
      4'd5:    coef_of = 16'd24573;
      4'd6:    coef_of = 16'd23198;
      4'd7:    coef_of = 16'd21900;
      4'd8:    coef_of = 16'd20675;
      4'd9:    coef_of = 16'd19519;
      4'd10:   coef_of = 16'd18427;
      default: coef_of = 16'd17396;
    endcase
  endfunction

  always_comb begin
    case (speed)
      2'b00:   span = (AW+1)'(SPAN_SLOW);
      2'b01:   span = (AW+1)'(SPAN_MID);
      default: span = (AW+1)'(SPAN_FAST);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgain  <= MW'(MUTE_FRAMES);
      dvalid <= 1'b0;
    end else begin
      dvalid <= frame;
      if (frame) begin
        if (soft_mute && mgain != '0)
          mgain <= mgain - 1'b1;
        else if (!soft_mute && mgain != MW'(MUTE_FRAMES))
          mgain <= mgain + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [7:0]           lvl, lvl_n, tgt, code;
    logic [AW-1:0]        acc, acc_n;
    logic [AW:0]          sum;
    logic [7:0]           att;
    logic [4:0]           sh;
    logic [3:0]           rem;
    logic [6:0]           shamt;
    logic signed [DW-1:0] x;
    logic signed [63:0]   prod, rnd, y;
    logic [DW-1:0]        scaled, out_q;

    assign tgt = target[c*8 +: 8];
    assign x   = din[c*DW +: DW];
    assign sum = {1'b0, acc} + (AW+1)'(STEP);

    always_comb begin
      lvl_n = lvl;
      acc_n = '0;
      if (!run) begin
        lvl_n = tgt;
      end else if (lvl != tgt) begin
        if (sum >= span) begin
          lvl_n = (lvl > tgt) ? lvl - 8'd1 : lvl + 8'd1;
          acc_n = AW'(sum - span);
        end else begin
          acc_n = AW'(sum);
        end
      end
    end

    assign code  = run ? lvl : 8'hFF;
    assign att   = 8'd255 - code;
    assign sh    = 5'(att / 8'd12);
    assign rem   = 4'(att % 8'd12);
    assign shamt = 7'(15 + MSH) + 7'(sh);

    always_comb begin
      prod = $signed({{(64-DW){x[DW-1]}}, x})
           * $signed({48'd0, coef_of(rem)})
           * $signed({{(64-MW){1'b0}}, mgain});
      rnd  = prod + (64'sd1 <<< (shamt - 7'd1));
      y    = rnd >>> shamt;
      if (code == 8'h00)  scaled = '0;
      else if (y > MAXV)  scaled = MAXV[DW-1:0];
      else if (y < MINV)  scaled = MINV[DW-1:0];
      else                scaled = y[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl   <= 8'hFF;
        acc   <= '0;
        out_q <= '0;
      end else if (frame) begin
        lvl   <= lvl_n;
        acc   <= acc_n;
        out_q <= scaled;
      end
    end

    assign dout[c*DW +: DW] = out_q;
    assign lvl_all[c*8 +: 8] = lvl;
  end

endmodule

module vol_ramp_chk #(
  parameter int CH = 2,
  parameter int DW = 24,
  parameter int MW = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             frame,
  input logic             dvalid,
  input logic [CH*DW-1:0] dout,
  input logic [CH*8-1:0]  target,
  input logic [CH*8-1:0]  lvl_all,
  input logic [MW-1:0]    mgain
);
  assert_valid_after_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> dvalid);
  assert_valid_only_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> !dvalid);
  assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(dout));
  assert_mute_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mgain <= MW'(1 << (MW - 1)));
  assert_mute_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(mgain));
  assert_level_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(lvl_all));

  for (genvar c = 0; c < CH; c++) begin : g_lv
    assert_level_slew_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame && run) |=> (lvl_all[c*8 +: 8] == $past(lvl_all[c*8 +: 8]) ||
                          lvl_all[c*8 +: 8] == $past(lvl_all[c*8 +: 8]) + 8'd1 ||
                          lvl_all[c*8 +: 8] == $past(lvl_all[c*8 +: 8]) - 8'd1));
    assert_level_snap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame && !run) |=> lvl_all[c*8 +: 8] == $past(target[c*8 +: 8]));
  end
endmodule

bind vol_ramp vol_ramp_chk #(.CH(CH), .DW(DW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .frame(frame), .dvalid(dvalid),
  .dout(dout), .target(target), .lvl_all(lvl_all), .mgain(mgain)
);

// File: tb/tb_vol_ramp.sv
module tb_vol_ramp;
  localparam int CH = 2;
  localparam int DW = 24;
  localparam int K[12] = '{32768, 30935, 29205, 27571, 26029, 24573,
                           23198, 21900, 20675, 19519, 18427, 17396};

  logic clk = 0, rst_n = 0, run = 1, frame = 0, soft_mute = 0;
  logic [1:0] speed = 2'b00;
  logic [CH*8-1:0] target = {CH{8'hFF}};
  logic [CH*DW-1:0] din = '0;
  logic [CH*DW-1:0] dout;
  logic dvalid;

  int n_chk = 0, n_bad = 0;
  int m_lvl[CH], m_acc[CH], m_mg;

  always #5 clk = ~clk;

  vol_ramp dut (.clk(clk), .rst_n(rst_n), .run(run), .frame(frame), .speed(speed),
                .soft_mute(soft_mute), .target(target), .din(din), .dout(dout), .dvalid(dvalid));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint gain_of(input longint x, input int code, input int mg);
    longint p, mx, mn;
    int a, s;
    if (code == 0) return 0;
    a = 255 - code;
    s = 25 + a / 12;
    p = x * K[a % 12] * mg;
    p = (p + (64'sd1 <<< (s - 1))) >>> s;
    mx = (64'sd1 <<< (DW - 1)) - 1;
    mn = -(64'sd1 <<< (DW - 1));
    if (p > mx) p = mx;
    if (p < mn) p = mn;
    return p;
  endfunction

  function automatic int span_of(input logic [1:0] sp);
    return sp == 2'b00 ? 7424 : sp == 2'b01 ? 1061 : 255;
  endfunction

  function automatic longint slice(input logic [CH*DW-1:0] v, input int c);
    logic signed [DW-1:0] t;
    t = v[c*DW +: DW];
    return longint'(t);
  endfunction

  task automatic do_frame(input string req);
    longint expv[CH];
    for (int c = 0; c < CH; c++)
      expv[c] = gain_of(slice(din, c), run ? m_lvl[c] : 255, m_mg);
    frame = 1;
    @(negedge clk);
    frame = 0;
    chk(dvalid == 1'b1, "R10", dvalid, 1);
    for (int c = 0; c < CH; c++)
      chk(slice(dout, c) == expv[c], req, slice(dout, c), expv[c]);
    for (int c = 0; c < CH; c++) begin
      int t = int'(target[c*8 +: 8]);
      if (!run) begin m_lvl[c] = t; m_acc[c] = 0; end
      else if (m_lvl[c] == t) m_acc[c] = 0;
      else begin
        int s = m_acc[c] + 255;
        if (s >= span_of(speed)) begin
          m_lvl[c] += (m_lvl[c] > t) ? -1 : 1;
          m_acc[c] = s - span_of(speed);
        end else m_acc[c] = s;
      end
    end
    if (soft_mute && m_mg > 0) m_mg--;
    else if (!soft_mute && m_mg < 1024) m_mg++;
    @(negedge clk);
    chk(dvalid == 1'b0, "R10", dvalid, 0);
    @(negedge clk);
  endtask

  task automatic snap_all(input logic [7:0] code);
    target = {CH{code}};
    run = 0;
    do_frame("R6");
    run = 1;
  endtask

  task automatic walk_count(input logic [1:0] sp, input int exp_frames, input string req);
    int k;
    snap_all(8'hFF);
    speed = sp;
    din = {24'sd4000000, 24'sd8388607};
    target[7:0] = 8'h00;
    k = 0;
    while (k < 9000) begin
      k++;
      do_frame(req);
      if (slice(dout, 0) == 0) break;
    end
    chk(k == exp_frames, req, k, exp_frames);
    chk(slice(dout, 1) == 4000000, "R11", slice(dout, 1), 4000000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h00C0FFEE));
    for (int c = 0; c < CH; c++) begin m_lvl[c] = 255; m_acc[c] = 0; end
    m_mg = 1024;
    repeat (3) @(negedge clk);
    chk(dout == '0, "R1", longint'(dout), 0);
    chk(dvalid == 1'b0, "R1", dvalid, 0);
    rst_n = 1;
    @(negedge clk);

    din = {-24'sd1234567, 24'sd7654321};
    do_frame("R1");

    din = {24'sh800000, 24'sh7FFFFF};
    foreach (K[i]) begin
      snap_all(8'(255 - i));
      do_frame("R2");
    end
    snap_all(8'hF3); do_frame("R2");
    snap_all(8'h01); do_frame("R2");
    chk(slice(dout, 0) != 0, "R2", slice(dout, 0), 1);
    din = {24'sd3, -24'sd2};
    snap_all(8'hFE); do_frame("R2");
    din = {24'sh7FFFFF, 24'sh800000};
    snap_all(8'h00); do_frame("R3");
    chk(dout == '0, "R3", longint'(dout), 0);

    target = {8'h80, 8'h40};
    run = 0; do_frame("R6");
    run = 1; do_frame("R6");
    chk(slice(dout, 0) == gain_of(-8388608, 8'h40, 1024), "R6",
        slice(dout, 0), gain_of(-8388608, 8'h40, 1024));

    walk_count(2'b00, 7425, "R4");
    walk_count(2'b01, 1062, "R4");
    walk_count(2'b10, 256, "R5");
    walk_count(2'b11, 256, "R5");

    snap_all(8'hFF);
    din = {24'sd5000000, 24'sd8388607};
    soft_mute = 1;
    k = 0;
    while (k < 1200) begin
      k++;
      do_frame("R7");
      if (slice(dout, 0) == 0) break;
    end
    chk(k == 1025, "R7", k, 1025);
    chk(dout == '0, "R7", longint'(dout), 0);
    soft_mute = 0;
    repeat (1024) do_frame("R7");
    soft_mute = 1;
    repeat (300) do_frame("R8");
    soft_mute = 0;
    repeat (300) do_frame("R8");
    do_frame("R8");
    chk(slice(dout, 0) == 8388607, "R8", slice(dout, 0), 8388607);

    snap_all(8'hFF);
    target = {8'hFF, 8'h80};
    speed = 2'b10;
    soft_mute = 1;
    repeat (200) do_frame("R9");

    for (int f = 0; f < 3000; f++) begin
      for (int c = 0; c < CH; c++) begin
        int r = $urandom_range(0, 9);
        din[c*DW +: DW] = r == 0 ? 24'h7FFFFF : r == 1 ? 24'h800000 : 24'($urandom);
        if ($urandom_range(0, 49) == 0) begin
          int p = $urandom_range(0, 3);
          target[c*8 +: 8] = p == 0 ? 8'h00 : p == 1 ? 8'hFF : 8'($urandom);
        end
      end
      if ($urandom_range(0, 199) == 0) speed = 2'($urandom);
      if ($urandom_range(0, 149) == 0) soft_mute = ~soft_mute;
      run = ($urandom_range(0, 299) != 0);
      do_frame("R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule